// File: doc/BRIEF.md
# Decade Counter with Ripple-Blanked Seven-Segment Output

This block counts clock edges modulo ten and shows the current count on one seven-segment digit. The count is held in a five-bit twisted-ring (Johnson) register, which has ten legal states. A decoder reads that register and drives the seven segment lines directly. A carry output runs at one tenth of the clock rate, so it can serve as the count clock of the next decade. An inhibit input stops the count without gating the clock. If the ring is ever found in one of its twenty-two illegal states, the next enabled clock returns it to zero.

A multi-digit display connects several of these blocks in a chain through a ripple-blank input and a ripple-blank output. On the integer side the chain runs from the most significant digit downward. On the fraction side it runs from the least significant digit upward. With this wiring, zeros that carry no meaning go dark: an eight-digit value of 0050.0700 reads as 50.07. If a stage's ripple-blank input is tied high, that stage shows its zero. This gives the optional zero before a decimal point. A lamp-test input lights every segment so that a dead display element can be spotted.

Top module: `decade_display_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, the count becomes 0. This holds even if `clkInhibit` is high. Afterwards `carryOut` is high.
- R2: At each rising edge where `rst` and `clkInhibit` are both low, the count moves from n to (n+1) mod 10.
- R3: At a rising edge where `clkInhibit` is high and `rst` is low, the count keeps its value.
- R4: `carryOut` is high for counts 0 to 4 and low for counts 5 to 9. It therefore rises only on the wrap from 9 to 0.
- R5: `seg` bit 0 is segment a, and bits 1 to 6 are segments b to g, all active high. When the digit is shown, the codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex). Digit 6 lights segment a, and digit 9 lights segment d.
- R6: When `lampTest` is high, `seg` is 7F for any count and any `rippleIn`. Lamp test has no effect on `rippleOut`.
- R7: When the count is 0, `rippleIn` is low and `lampTest` is low, `seg` is 0 and `rippleOut` is low.
- R8: When the count is 0 and `rippleIn` is high, the zero code 3F is shown and `rippleOut` is high.
- R9: When the count is not 0, the digit is always shown, whatever the value of `rippleIn`, and `rippleOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; sets the count to 0 |
| clkInhibit | input | 1 | When high, clock edges do not advance the count |
| rippleIn | input | 1 | Low allows a zero on this digit to be blanked |
| lampTest | input | 1 | When high, all segments are lit |
| seg | output | 7 | Segment lines a (bit 0) to g (bit 6), active high |
| rippleOut | output | 1 | Low only when this stage blanked a zero; connects to the next stage's `rippleIn` |
| carryOut | output | 1 | Clock divided by ten; rises on the wrap from 9 to 0 |

## Verification
The assertions assume that `rst` is held high from time zero through the first clock edges. They also assume that all inputs are stable at the rising edge, because the segment and ripple outputs follow `lampTest` and `rippleIn` without a register. The stimulus changes every input only on the falling edge. It holds reset before any count is taken. It varies inhibit, lamp test and ripple-blank input in interleaved periodic patterns, so that zero is visited with both ripple-blank values while lamp test sometimes overlaps. An eight-digit chain in the bench checks the decimal-point blanking pattern against values worked out digit by digit.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int RING_W = 5;
  localparam int NUM_DIGITS = 2 * RING_W;
  localparam int DIGIT_W = $clog2(NUM_DIGITS);
  localparam int SEG_W = 7;

  typedef struct packed {
    logic clear;
    logic advance;
  } ringCmd_t;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic     rst,
  input  logic     clkInhibit,
  output ringCmd_t cmd
);
  always_comb begin
    cmd.clear   = rst;
    cmd.advance = !rst && !clkInhibit;
  end
endmodule

// File: rtl/decade_ring.sv
module decade_ring
  import decade_pkg::*;
(
  input  logic               clk,
  input  ringCmd_t           cmd,
  output logic [DIGIT_W-1:0] digit,
  output logic               isZero,
  output logic               carry
);
  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] ringNext;
  logic              legal;
  logic [DIGIT_W:0]  onesCount;

  // A legal twisted-ring word has at most one boundary between neighbouring bits.
  always_comb begin
    int edges;
    edges = 0;
    for (int i = 0; i < RING_W - 1; i++) begin
      if (ring[i] != ring[i+1]) edges++;
    end
    legal = (edges <= 1);
  end

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < RING_W; i++) begin
      onesCount = onesCount + {{DIGIT_W{1'b0}}, ring[i]};
    end
  end

  always_comb begin
    if (legal) ringNext = {ring[RING_W-2:0], ~ring[RING_W-1]};
    else       ringNext = '0;
  end

  always_ff @(posedge clk) begin
    if (cmd.clear)        ring <= '0;
    else if (cmd.advance) ring <= ringNext;
  end

  localparam logic [DIGIT_W:0] TOP = (DIGIT_W+1)'(NUM_DIGITS);

  always_comb begin
    logic [DIGIT_W:0] value;
    if (ring[RING_W-1]) value = TOP - onesCount;
    else                value = onesCount;
    digit  = value[DIGIT_W-1:0];
    isZero = (ring == '0);
    carry  = ~ring[RING_W-1];
  end
endmodule

// File: rtl/decade_seg_decode.sv
module decade_seg_decode
  import decade_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               isZero,
  input  logic               rippleIn,
  input  logic               lampTest,
  output logic [SEG_W-1:0]   seg,
  output logic               rippleOut
);
  logic [SEG_W-1:0] glyph;
  logic             blankNow;

  always_comb begin
    case (digit)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = '0;
    endcase
  end

  always_comb begin
    blankNow  = isZero && !rippleIn;
    rippleOut = !blankNow;
    if (lampTest)      seg = '1;
    else if (blankNow) seg = '0;
    else               seg = glyph;
  end
endmodule

// File: rtl/decade_display_counter.sv
module decade_display_counter
  import decade_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clkInhibit,
  input  logic             rippleIn,
  input  logic             lampTest,
  output logic [SEG_W-1:0] seg,
  output logic             rippleOut,
  output logic             carryOut
);
  ringCmd_t           cmd;
  logic [DIGIT_W-1:0] digit;
  logic               isZero;

  decade_ctrl u_ctrl (
    .rst        (rst),
    .clkInhibit (clkInhibit),
    .cmd        (cmd)
  );

  decade_ring u_ring (
    .clk    (clk),
    .cmd    (cmd),
    .digit  (digit),
    .isZero (isZero),
    .carry  (carryOut)
  );

  decade_seg_decode u_dec (
    .digit     (digit),
    .isZero    (isZero),
    .rippleIn  (rippleIn),
    .lampTest  (lampTest),
    .seg       (seg),
    .rippleOut (rippleOut)
  );
endmodule

// File: rtl/decade_display_counter_checker.sv
module decade_display_counter_checker (
  input logic       clk,
  input logic       rst,
  input logic       clkInhibit,
  input logic       rippleIn,
  input logic       lampTest,
  input logic [6:0] seg,
  input logic       rippleOut,
  input logic       carryOut
);
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (carryOut && (lampTest ? seg == 7'h7F : (rippleIn ? seg == 7'h3F : seg == 7'h00))));

  p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (clkInhibit && !$past(rst)) |=> $stable(carryOut));

  p_carry_rise_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(carryOut) && !$past(rst)) |-> $past(!clkInhibit));

  p_glyph_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (!lampTest && rippleOut) |-> (seg inside {7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                              7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F}));

  p_lamp_all_r6: assert property (@(posedge clk) disable iff (rst)
    lampTest |-> seg == 7'h7F);

  p_blank_dark_r7: assert property (@(posedge clk) disable iff (rst)
    (!rippleOut && !lampTest) |-> seg == 7'h00);

  p_blank_needs_low_in_r7: assert property (@(posedge clk) disable iff (rst)
    !rippleOut |-> !rippleIn);

  p_high_in_passes_r8: assert property (@(posedge clk) disable iff (rst)
    rippleIn |-> rippleOut);
endmodule

bind decade_display_counter decade_display_counter_checker u_checker (
  .clk        (clk),
  .rst        (rst),
  .clkInhibit (clkInhibit),
  .rippleIn   (rippleIn),
  .lampTest   (lampTest),
  .seg        (seg),
  .rippleOut  (rippleOut),
  .carryOut   (carryOut)
);

// File: tb/decade_display_counter_bench.sv
module decade_display_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clkInhibit = 1'b0;
  logic       rippleIn = 1'b1;
  logic       lampTest = 1'b0;
  logic [6:0] seg;
  logic       rippleOut;
  logic       carryOut;

  int runCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decade_display_counter u_decade_display_counter (
    .clk(clk), .rst(rst), .clkInhibit(clkInhibit), .rippleIn(rippleIn),
    .lampTest(lampTest), .seg(seg), .rippleOut(rippleOut), .carryOut(carryOut)
  );

  // Eight-digit chain: index 7..4 integer side, 3..0 fraction side.
  logic [7:0] chInh = '0;
  logic [7:0] chIn;
  logic [7:0] chOut;
  logic [6:0] chSeg [8];
  logic [7:0] chCarry;
  logic       forceLead = 1'b0;

  assign chIn[7] = 1'b0;
  assign chIn[6] = chOut[7];
  assign chIn[5] = chOut[6];
  assign chIn[4] = chOut[5] | forceLead;
  assign chIn[0] = 1'b0;
  assign chIn[1] = chOut[0];
  assign chIn[2] = chOut[1];
  assign chIn[3] = chOut[2];

  for (genvar g = 0; g < 8; g++) begin : gChain
    decade_display_counter u_digit (
      .clk(clk), .rst(rst), .clkInhibit(chInh[g]), .rippleIn(chIn[g]),
      .lampTest(1'b0), .seg(chSeg[g]), .rippleOut(chOut[g]), .carryOut(chCarry[g])
    );
  end

  function automatic logic [6:0] glyphOf(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    runCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic loadChain(input logic [31:0] v, input logic lead);
    forceLead = lead;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 9; k++) begin
      for (int i = 0; i < 8; i++) chInh[i] = (k >= int'(v[4*i +: 4]));
      @(negedge clk);
    end
    chInh = '1;
    @(negedge clk);
    begin
      bit stillLead;
      stillLead = 1'b1;
      for (int i = 7; i >= 4; i--) begin
        int d;
        logic inHigh;
        d = int'(v[4*i +: 4]);
        inHigh = !stillLead || (i == 4 && lead);
        if (d == 0 && !inHigh) begin
          check("R7 chain integer blank", chSeg[i], 0);
        end else if (d == 0) begin
          check("R8 chain integer zero shown", chSeg[i], glyphOf(0));
          stillLead = 1'b0;
        end else begin
          check("R9 chain integer digit", chSeg[i], glyphOf(d));
          stillLead = 1'b0;
        end
      end
      stillLead = 1'b1;
      for (int i = 0; i < 4; i++) begin
        int d;
        d = int'(v[4*i +: 4]);
        if (d == 0 && stillLead) begin
          check("R7 chain fraction blank", chSeg[i], 0);
        end else begin
          check("R9 chain fraction digit", chSeg[i], glyphOf(d));
          stillLead = 1'b0;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    int expCount;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset glyph", seg, 7'h3F);
    check("R1 reset carry", carryOut, 1);
    check("R1 reset rippleOut", rippleOut, 1);
    expCount = 0;

    // Plain sweep over all digits, shown unconditionally.
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      expCount = (expCount + 1) % 10;
      check("R5 glyph code", seg, glyphOf(expCount));
      check("R4 carry level", carryOut, expCount < 5 ? 1 : 0);
    end

    // Mixed inhibit, lamp test and ripple-in patterns.
    for (int c = 0; c < 120; c++) begin
      logic inh;
      inh = (c % 3 == 2);
      clkInhibit = inh;
      lampTest   = (c % 7 == 5);
      rippleIn   = (c % 11) < 5;
      @(negedge clk);
      if (!inh) expCount = (expCount + 1) % 10;
      check("R4 carry", carryOut, expCount < 5 ? 1 : 0);
      if (lampTest) begin
        check("R6 lamp test segments", seg, 7'h7F);
        check("R6 lamp leaves rippleOut", rippleOut, (expCount == 0 && !rippleIn) ? 0 : 1);
      end else if (expCount == 0 && !rippleIn) begin
        check("R7 zero blanked", seg, 0);
        check("R7 rippleOut low", rippleOut, 0);
      end else if (expCount == 0) begin
        check("R8 zero shown", seg, glyphOf(0));
        check("R8 rippleOut high", rippleOut, 1);
      end else begin
        check(inh ? "R3 hold under inhibit" : "R2 advance", seg, glyphOf(expCount));
        check("R9 rippleOut high for nonzero", rippleOut, 1);
      end
    end

    // Reset takes priority over inhibit.
    lampTest = 1'b0;
    rippleIn = 1'b1;
    clkInhibit = 1'b0;
    while (expCount != 7) begin
      @(negedge clk);
      expCount = (expCount + 1) % 10;
    end
    clkInhibit = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset under inhibit", seg, 7'h3F);
    check("R1 reset under inhibit carry", carryOut, 1);
    clkInhibit = 1'b0;

    // Carry rises only at the wrap.
    begin
      int rises;
      logic prevCarry;
      rises = 0;
      prevCarry = carryOut;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (carryOut && !prevCarry) rises++;
        prevCarry = carryOut;
      end
      check("R4 carry rises per 30 clocks", rises, 3);
    end

    loadChain(32'h0050_0700, 1'b0);
    loadChain(32'h0000_7346, 1'b1);
    loadChain(32'h0763_0000, 1'b0);
    loadChain(32'h1200_0009, 1'b0);

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule